// File: doc/BRIEF.md
# Cache-Maintenance Command Decoder

This block sits behind a coprocessor register port. It turns one access to the cache-operations register space into exactly one of three outcomes: a one-hot operation strobe, a one-hot status-read select, or an undefined-instruction flag. The access carries a direction (read or write), a privilege bit, and the CRm, Opcode_1 and Opcode_2 fields. The outcome depends on all of these together. An encoding can be legal in one direction and not the other, and legal in privileged mode but not in User mode. The architecturally unified-cache encodings are accepted silently as no-ops when privileged and fault in User mode.

On an accepted write, the block also formats the register argument. Address bits below the line size are cleared for line operations. Bits below the entry granule are cleared for a single branch-target flush. Set/way arguments pass through unchanged, and should-be-zero operations produce a zero argument. It raises separate one-cycle strobes for the two barrier kinds and for wait-for-interrupt. On an accepted read it returns the chosen status flag in bit 0 of a zero-filled word. All outputs are registered and appear in the cycle after the access is presented. The maintenance work, barrier completion and clock gating are done elsewhere.

Top module: `cmo_decode`

## Requirements
- R1: A write with CRm=10, Opcode_2=4 raises op_vec bit 13 and dsb_pulse. A write with CRm=10, Opcode_2=5 raises op_vec bit 14 and dmb_pulse. Both are accepted in User and privileged mode.
- R2: A write with CRm=0, Opcode_2=4 raises op_vec bit 20 and wfi_pulse when privileged. In User mode it is undefined.
- R3: A privileged read with CRm=10, Opcode_2=6 sets rd_sel bit 0 and returns dirty_in in rd_data bit 0. A write to this encoding, or any User-mode access to it, is undefined.
- R4: A read with CRm=12, Opcode_2=4 sets rd_sel bit 1 and returns xfer_busy_in in rd_data bit 0, in either mode. A write to this encoding is undefined.
- R5: Writes are accepted in both modes for two encodings: CRm=12, Opcode_2=5 (stop prefetch range, op_vec bit 15) and CRm=5, Opcode_2=4 (flush prefetch buffer, op_vec bit 3).
- R6: The branch-target flushes are privileged-only writes: CRm=5, Opcode_2=6 (all entries, bit 4) and CRm=5, Opcode_2=7 (one entry, bit 5). In User mode they are undefined.
- R7: Writes with CRm=7 and Opcode_2 from 1 to 7, and writes with CRm=11 or CRm=15 and any Opcode_2, raise op_vec bit 21 (no-op) when privileged. They are undefined in User mode. Reads of these encodings are undefined.
- R8: A read of any encoding that is only defined for writes is undefined.
- R9: Any encoding not listed here is undefined, and so is any access with nonzero Opcode_1.
- R10: arg_out is zero unless an operation strobe fires. Line operations (bits 1, 7, 11, 16, 18) clear acc_data[4:0]. The single branch-target flush (bit 5) clears acc_data[2:0]. Set/way operations (bits 2, 8, 12, 19) pass acc_data unchanged. All other operations give zero.
- R11: One cycle after an access, exactly one of op_vec, rd_sel and undef is nonzero. With no access, all outputs are zero. rd_data is zero unless rd_sel is set.
- R12: The privileged-only maintenance writes map from (CRm, Opcode_2) to op_vec bits as follows:
  - CRm=5: (5,0) to bit 0, (5,1) to bit 1, (5,2) to bit 2.
  - CRm=6: (6,0) to bit 6, (6,1) to bit 7, (6,2) to bit 8.
  - CRm=7: (7,0) to bit 9.
  - CRm=10: (10,0) to bit 10, (10,1) to bit 11, (10,2) to bit 12.
  - CRm=13: (13,1) to bit 16.
  - CRm=14: (14,0) to bit 17, (14,1) to bit 18, (14,2) to bit 19.

  All of these are undefined in User mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | An access is presented this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_priv | input | 1 | 1 = privileged, 0 = User mode |
| acc_op1 | input | 3 | Opcode_1 field |
| acc_crm | input | 4 | CRm field |
| acc_op2 | input | 3 | Opcode_2 field |
| acc_data | input | DATA_W | Register argument of a write |
| dirty_in | input | 1 | Current cache dirty flag |
| xfer_busy_in | input | 1 | Current block-transfer activity flag |
| op_vec | output | 22 | One-hot operation strobe, bit map as in R1, R2, R5, R6, R7, R12 |
| rd_sel | output | 2 | One-hot status read: bit 0 dirty, bit 1 block transfer |
| undef | output | 1 | Undefined-instruction exception |
| arg_out | output | DATA_W | Formatted operation argument |
| rd_data | output | DATA_W | Status read data |
| dsb_pulse | output | 1 | Synchronization barrier strobe |
| dmb_pulse | output | 1 | Memory barrier strobe |
| wfi_pulse | output | 1 | Wait-for-interrupt strobe |

## Verification
The assertions assume that the inputs are stable and known at each sampled edge. They also assume that acc_valid is low throughout reset, so the first post-reset comparison against the previous cycle sees an idle access. The bench drives every input on the falling edge and holds acc_valid low during and right after reset. It then sweeps every combination of direction, mode, CRm, Opcode_2, and a zero or nonzero Opcode_1, with an idle cycle between accesses, which also exercises the quiet state.

// File: rtl/cmo_pkg.sv
// Shared encodings for the cache-maintenance decoder.
// Assumes the field widths of the coprocessor register port are fixed.
package cmo_pkg;
    localparam int OP1_W   = 3;
    localparam int CRM_W   = 4;
    localparam int OP2_W   = 3;
    localparam int NUM_OPS = 22;
    localparam int NUM_RD  = 2;
    localparam int OP_IDX_W = $clog2(NUM_OPS);

    typedef enum logic [OP_IDX_W-1:0] {
        OP_INV_I_ALL = 5'd0,  OP_INV_I_LINE = 5'd1,  OP_INV_I_SW  = 5'd2,
        OP_FLUSH_PFB = 5'd3,  OP_BTC_ALL    = 5'd4,  OP_BTC_ENTRY = 5'd5,
        OP_INV_D_ALL = 5'd6,  OP_INV_D_LINE = 5'd7,  OP_INV_D_SW  = 5'd8,
        OP_INV_BOTH  = 5'd9,  OP_CLN_D_ALL  = 5'd10, OP_CLN_D_LINE = 5'd11,
        OP_CLN_D_SW  = 5'd12, OP_SYNC_BAR   = 5'd13, OP_MEM_BAR   = 5'd14,
        OP_STOP_PFR  = 5'd15, OP_PF_I_LINE  = 5'd16, OP_CI_D_ALL  = 5'd17,
        OP_CI_D_LINE = 5'd18, OP_CI_D_SW    = 5'd19, OP_WAIT_IRQ  = 5'd20,
        OP_UNI_NOP   = 5'd21
    } op_e;

    typedef enum logic [1:0] {ARG_ZERO, ARG_LINE, ARG_ENTRY, ARG_RAW} arg_e;
    typedef enum logic [1:0] {CLS_NONE, CLS_WRITE, CLS_READ, CLS_NOP} cls_e;

    typedef struct packed {
        cls_e cls;
        logic user_ok;
        op_e  op;
        logic rd_idx;
        arg_e arg;
    } ent_t;
endpackage

// File: rtl/cmo_table.sv
// Encoding table: maps (CRm, Opcode_2) to an entry class, its operation or
// read index, its User-mode permission and its argument format.
// Assumes nothing about direction or mode; those are judged downstream.
module cmo_table
    import cmo_pkg::*;
(
    input  logic [CRM_W-1:0] crm,
    input  logic [OP2_W-1:0] op2,
    output ent_t             ent
);
    // Look up the entry for the encoding.
    always_comb begin
        ent = '{cls: CLS_NONE, user_ok: 1'b0, op: OP_UNI_NOP, rd_idx: 1'b0, arg: ARG_ZERO};
        case ({crm, op2})
            {4'd5,  3'd0}: begin ent.cls = CLS_WRITE; ent.op = OP_INV_I_ALL; end
            {4'd5,  3'd1}: begin ent.cls = CLS_WRITE; ent.op = OP_INV_I_LINE; ent.arg = ARG_LINE; end
            {4'd5,  3'd2}: begin ent.cls = CLS_WRITE; ent.op = OP_INV_I_SW;   ent.arg = ARG_RAW; end
            {4'd5,  3'd4}: begin ent.cls = CLS_WRITE; ent.op = OP_FLUSH_PFB;  ent.user_ok = 1'b1; end
            {4'd5,  3'd6}: begin ent.cls = CLS_WRITE; ent.op = OP_BTC_ALL; end
            {4'd5,  3'd7}: begin ent.cls = CLS_WRITE; ent.op = OP_BTC_ENTRY;  ent.arg = ARG_ENTRY; end
            {4'd6,  3'd0}: begin ent.cls = CLS_WRITE; ent.op = OP_INV_D_ALL; end
            {4'd6,  3'd1}: begin ent.cls = CLS_WRITE; ent.op = OP_INV_D_LINE; ent.arg = ARG_LINE; end
            {4'd6,  3'd2}: begin ent.cls = CLS_WRITE; ent.op = OP_INV_D_SW;   ent.arg = ARG_RAW; end
            {4'd7,  3'd0}: begin ent.cls = CLS_WRITE; ent.op = OP_INV_BOTH; end
            {4'd10, 3'd0}: begin ent.cls = CLS_WRITE; ent.op = OP_CLN_D_ALL; end
            {4'd10, 3'd1}: begin ent.cls = CLS_WRITE; ent.op = OP_CLN_D_LINE; ent.arg = ARG_LINE; end
            {4'd10, 3'd2}: begin ent.cls = CLS_WRITE; ent.op = OP_CLN_D_SW;   ent.arg = ARG_RAW; end
            {4'd10, 3'd4}: begin ent.cls = CLS_WRITE; ent.op = OP_SYNC_BAR;   ent.user_ok = 1'b1; end
            {4'd10, 3'd5}: begin ent.cls = CLS_WRITE; ent.op = OP_MEM_BAR;    ent.user_ok = 1'b1; end
            {4'd10, 3'd6}: begin ent.cls = CLS_READ;  ent.rd_idx = 1'b0; end
            {4'd12, 3'd4}: begin ent.cls = CLS_READ;  ent.rd_idx = 1'b1;      ent.user_ok = 1'b1; end
            {4'd12, 3'd5}: begin ent.cls = CLS_WRITE; ent.op = OP_STOP_PFR;   ent.user_ok = 1'b1; end
            {4'd13, 3'd1}: begin ent.cls = CLS_WRITE; ent.op = OP_PF_I_LINE;  ent.arg = ARG_LINE; end
            {4'd14, 3'd0}: begin ent.cls = CLS_WRITE; ent.op = OP_CI_D_ALL; end
            {4'd14, 3'd1}: begin ent.cls = CLS_WRITE; ent.op = OP_CI_D_LINE;  ent.arg = ARG_LINE; end
            {4'd14, 3'd2}: begin ent.cls = CLS_WRITE; ent.op = OP_CI_D_SW;    ent.arg = ARG_RAW; end
            {4'd0,  3'd4}: begin ent.cls = CLS_WRITE; ent.op = OP_WAIT_IRQ; end
            default: begin
                if ((crm == 4'd7) || (crm == 4'd11) || (crm == 4'd15)) begin
                    ent.cls = CLS_NOP;
                end
            end
        endcase
    end
endmodule

// File: rtl/cmo_access.sv
// Access judge: combines a table entry with direction, mode and Opcode_1
// into one of operation, status read or undefined.
// Assumes the entry comes from cmo_table for the same access.
module cmo_access
    import cmo_pkg::*;
(
    input  ent_t ent,
    input  logic is_write,
    input  logic is_priv,
    input  logic op1_zero,
    output logic grant_op,
    output logic grant_rd,
    output logic deny
);
    logic dir_ok;
    logic mode_ok;
    logic ok;

    // Decide whether direction and mode permit the entry.
    always_comb begin
        dir_ok  = ((ent.cls == CLS_WRITE) || (ent.cls == CLS_NOP)) ? is_write
                : (ent.cls == CLS_READ) ? !is_write : 1'b0;
        mode_ok = is_priv || ent.user_ok;
        ok      = op1_zero && dir_ok && mode_ok;
        grant_op = ok && (ent.cls != CLS_READ);
        grant_rd = ok && (ent.cls == CLS_READ);
        deny     = !ok;
    end
endmodule

// File: rtl/cmo_argfmt.sv
// Argument formatter: clears the ignored low bits of an address argument,
// passes set/way words through and zeroes should-be-zero arguments.
// Assumes LINE_LSB and ENTRY_LSB are below DATA_W.
module cmo_argfmt
    import cmo_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int LINE_LSB  = 5,
    parameter int ENTRY_LSB = 3
) (
    input  arg_e              kind,
    input  logic [DATA_W-1:0] data,
    output logic [DATA_W-1:0] arg
);
    localparam logic [DATA_W-1:0] LINE_MASK  = {DATA_W{1'b1}} << LINE_LSB;
    localparam logic [DATA_W-1:0] ENTRY_MASK = {DATA_W{1'b1}} << ENTRY_LSB;

    // Select the format for the argument kind.
    always_comb begin
        case (kind)
            ARG_LINE:  arg = data & LINE_MASK;
            ARG_ENTRY: arg = data & ENTRY_MASK;
            ARG_RAW:   arg = data;
            default:   arg = '0;
        endcase
    end
endmodule

// File: rtl/cmo_decode.sv
// Cache-maintenance command decoder, top level. Registers one outcome per
// access: operation strobe, status read select or undefined flag, plus the
// formatted argument, status read data and barrier / wait strobes.
// Assumes acc_valid is low during reset; outputs follow inputs by one cycle.
module cmo_decode
    import cmo_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int LINE_LSB  = 5,
    parameter int ENTRY_LSB = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               acc_valid,
    input  logic               acc_write,
    input  logic               acc_priv,
    input  logic [OP1_W-1:0]   acc_op1,
    input  logic [CRM_W-1:0]   acc_crm,
    input  logic [OP2_W-1:0]   acc_op2,
    input  logic [DATA_W-1:0]  acc_data,
    input  logic               dirty_in,
    input  logic               xfer_busy_in,
    output logic [NUM_OPS-1:0] op_vec,
    output logic [NUM_RD-1:0]  rd_sel,
    output logic               undef,
    output logic [DATA_W-1:0]  arg_out,
    output logic [DATA_W-1:0]  rd_data,
    output logic               dsb_pulse,
    output logic               dmb_pulse,
    output logic               wfi_pulse
);
    ent_t              ent;
    logic              grant_op;
    logic              grant_rd;
    logic              deny;
    logic [DATA_W-1:0] fmt_arg;
    logic [NUM_OPS-1:0] op_d;
    logic [NUM_RD-1:0]  rd_d;
    logic               rd_bit_d;

    cmo_table u_table (
        .crm (acc_crm),
        .op2 (acc_op2),
        .ent (ent)
    );

    cmo_access u_access (
        .ent      (ent),
        .is_write (acc_write),
        .is_priv  (acc_priv),
        .op1_zero (acc_op1 == '0),
        .grant_op (grant_op),
        .grant_rd (grant_rd),
        .deny     (deny)
    );

    cmo_argfmt #(
        .DATA_W    (DATA_W),
        .LINE_LSB  (LINE_LSB),
        .ENTRY_LSB (ENTRY_LSB)
    ) u_argfmt (
        .kind (ent.arg),
        .data (acc_data),
        .arg  (fmt_arg)
    );

    // One-hot expansion of the granted operation index.
    for (genvar g = 0; g < NUM_OPS; g++) begin : g_op
        assign op_d[g] = acc_valid && grant_op && (ent.op == op_e'(g));
    end

    // One-hot expansion of the granted status read index.
    for (genvar g = 0; g < NUM_RD; g++) begin : g_rd
        assign rd_d[g] = acc_valid && grant_rd && (ent.rd_idx == 1'(g));
    end

    // Pick the status flag for a granted read.
    always_comb begin
        rd_bit_d = 1'b0;
        if (rd_d[0]) rd_bit_d = dirty_in;
        if (rd_d[1]) rd_bit_d = xfer_busy_in;
    end

    // Register every outcome of the access.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_vec    <= '0;
            rd_sel    <= '0;
            undef     <= 1'b0;
            arg_out   <= '0;
            rd_data   <= '0;
            dsb_pulse <= 1'b0;
            dmb_pulse <= 1'b0;
            wfi_pulse <= 1'b0;
        end else begin
            op_vec    <= op_d;
            rd_sel    <= rd_d;
            undef     <= acc_valid && deny;
            arg_out   <= (acc_valid && grant_op) ? fmt_arg : '0;
            rd_data   <= {{(DATA_W-1){1'b0}}, rd_bit_d};
            dsb_pulse <= op_d[OP_SYNC_BAR];
            dmb_pulse <= op_d[OP_MEM_BAR];
            wfi_pulse <= op_d[OP_WAIT_IRQ];
        end
    end
endmodule

// File: rtl/cmo_decode_chk.sv
// Checker for cmo_decode: relates the registered outcomes to the access
// presented one cycle earlier. Assumes acc_valid is low during reset.
module cmo_decode_chk
    import cmo_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               acc_valid,
    input logic               acc_write,
    input logic               acc_priv,
    input logic [OP1_W-1:0]   acc_op1,
    input logic [CRM_W-1:0]   acc_crm,
    input logic [OP2_W-1:0]   acc_op2,
    input logic [NUM_OPS-1:0] op_vec,
    input logic [NUM_RD-1:0]  rd_sel,
    input logic               undef,
    input logic [DATA_W-1:0]  arg_out,
    input logic               dsb_pulse,
    input logic               wfi_pulse
);
    AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc_valid) |-> ($countones({op_vec, rd_sel, undef}) == 1)); // R11
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(acc_valid) |-> ({op_vec, rd_sel, undef} == '0)); // R11
    AST_SYNC_ANY_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc_valid && acc_write && acc_op1 == 0 && acc_crm == 4'd10 && acc_op2 == 3'd4)
        |-> dsb_pulse); // R1
    AST_WAIT_USER_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc_valid && !acc_priv && acc_crm == 4'd0 && acc_op2 == 3'd4) |-> (undef && !wfi_pulse)); // R2
    AST_DIRTY_USER_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc_valid && !acc_priv && acc_crm == 4'd10 && acc_op2 == 3'd6) |-> undef); // R3
    AST_READ_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel != '0) |-> $past(acc_valid && !acc_write)); // R8
    AST_OP1_UNDEF: assert property (@(posedge clk) disable iff (!rst_n)
        $past(acc_valid && acc_op1 != 0) |-> undef); // R9
    AST_LINE_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (op_vec[OP_CLN_D_LINE] || op_vec[OP_INV_D_LINE] || op_vec[OP_CI_D_LINE]) |-> (arg_out[4:0] == 5'd0)); // R10
endmodule

bind cmo_decode cmo_decode_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .acc_priv  (acc_priv),
    .acc_op1   (acc_op1),
    .acc_crm   (acc_crm),
    .acc_op2   (acc_op2),
    .op_vec    (op_vec),
    .rd_sel    (rd_sel),
    .undef     (undef),
    .arg_out   (arg_out),
    .dsb_pulse (dsb_pulse),
    .wfi_pulse (wfi_pulse)
);

// File: tb/cmo_decode_test.sv
// Exhaustive sweep of direction, mode, CRm, Opcode_2 and Opcode_1 for the
// cache-maintenance decoder, with an independent expectation model.
module cmo_decode_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_write = 1'b0;
    logic        acc_priv = 1'b0;
    logic [2:0]  acc_op1 = '0;
    logic [3:0]  acc_crm = '0;
    logic [2:0]  acc_op2 = '0;
    logic [31:0] acc_data = '0;
    logic        dirty_in = 1'b0;
    logic        xfer_busy_in = 1'b0;
    logic [21:0] op_vec;
    logic [1:0]  rd_sel;
    logic        undef;
    logic [31:0] arg_out;
    logic [31:0] rd_data;
    logic        dsb_pulse;
    logic        dmb_pulse;
    logic        wfi_pulse;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cmo_decode uut (
        .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
        .acc_priv(acc_priv), .acc_op1(acc_op1), .acc_crm(acc_crm), .acc_op2(acc_op2),
        .acc_data(acc_data), .dirty_in(dirty_in), .xfer_busy_in(xfer_busy_in),
        .op_vec(op_vec), .rd_sel(rd_sel), .undef(undef), .arg_out(arg_out),
        .rd_data(rd_data), .dsb_pulse(dsb_pulse), .dmb_pulse(dmb_pulse), .wfi_pulse(wfi_pulse)
    );

    // Expected entry from the requirement text: kind 0 none, 1 write op, 2 read, 3 no-op.
    // fmt 0 zero, 1 clear [4:0], 2 clear [2:0], 3 raw.
    task automatic model(input int crm, input int op2, output int kind, output int idx,
                         output bit user, output int fmt, output string tag);
        kind = 0; idx = 0; user = 0; fmt = 0; tag = "R9";
        if (crm == 10 && op2 == 4) begin kind = 1; idx = 13; user = 1; tag = "R1"; end
        else if (crm == 10 && op2 == 5) begin kind = 1; idx = 14; user = 1; tag = "R1"; end
        else if (crm == 0 && op2 == 4) begin kind = 1; idx = 20; tag = "R2"; end
        else if (crm == 10 && op2 == 6) begin kind = 2; idx = 0; tag = "R3"; end
        else if (crm == 12 && op2 == 4) begin kind = 2; idx = 1; user = 1; tag = "R4"; end
        else if (crm == 12 && op2 == 5) begin kind = 1; idx = 15; user = 1; tag = "R5"; end
        else if (crm == 5 && op2 == 4) begin kind = 1; idx = 3; user = 1; tag = "R5"; end
        else if (crm == 5 && op2 == 6) begin kind = 1; idx = 4; tag = "R6"; end
        else if (crm == 5 && op2 == 7) begin kind = 1; idx = 5; fmt = 2; tag = "R6"; end
        else if ((crm == 5 || crm == 6 || crm == 10 || crm == 14) && op2 <= 2) begin
            kind = 1; tag = "R12";
            fmt = (op2 == 0) ? 0 : (op2 == 1) ? 1 : 3;
            case (crm)
                5:  idx = op2;
                6:  idx = 6 + op2;
                10: idx = 10 + op2;
                default: idx = 17 + op2;
            endcase
        end
        else if (crm == 7 && op2 == 0) begin kind = 1; idx = 9; tag = "R12"; end
        else if (crm == 13 && op2 == 1) begin kind = 1; idx = 16; fmt = 1; tag = "R12"; end
        else if (crm == 7 || crm == 11 || crm == 15) begin kind = 3; idx = 21; tag = "R7"; end
    endtask

    task automatic fail(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        errors++;
        $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    endtask

    // Present one access, then compare the registered result one cycle later.
    task automatic run_one(input bit w, input bit p, input int op1, input int crm, input int op2,
                           input logic [31:0] data, input bit dty, input bit busy);
        int kind, idx, fmt;
        bit user, ok;
        string tag;
        logic [21:0] e_op;
        logic [1:0]  e_rd;
        logic [31:0] e_arg, e_rdd;
        model(crm, op2, kind, idx, user, fmt, tag);
        if (op1 != 0) tag = "R9";
        else if (kind == 1 && !w) tag = "R8";
        ok = (op1 == 0) && (kind != 0) && ((kind == 2) ? !w : w) && (p || user);
        e_op = '0; e_rd = '0; e_arg = '0; e_rdd = '0;
        if (ok && kind != 2) begin
            e_op[idx] = 1'b1;
            case (fmt)
                1: e_arg = data & ~32'h1F;
                2: e_arg = data & ~32'h7;
                3: e_arg = data;
                default: e_arg = '0;
            endcase
        end
        if (ok && kind == 2) begin
            e_rd[idx] = 1'b1;
            e_rdd = {31'd0, (idx == 0) ? dty : busy};
        end
        @(negedge clk);
        acc_valid = 1'b1; acc_write = w; acc_priv = p; acc_op1 = 3'(op1);
        acc_crm = 4'(crm); acc_op2 = 3'(op2); acc_data = data;
        dirty_in = dty; xfer_busy_in = busy;
        @(negedge clk);
        acc_valid = 1'b0;
        checks++;
        if (op_vec !== e_op) fail(tag, "op_vec", 64'(op_vec), 64'(e_op));
        else if (rd_sel !== e_rd) fail(tag, "rd_sel", 64'(rd_sel), 64'(e_rd));
        else if (undef !== !ok) fail(tag, "undef", 64'(undef), 64'(!ok));
        else if (rd_data !== e_rdd) fail(tag, "rd_data", 64'(rd_data), 64'(e_rdd));
        else if ({dsb_pulse, dmb_pulse, wfi_pulse} !== {e_op[13], e_op[14], e_op[20]})
            fail(tag, "strobes", 64'({dsb_pulse, dmb_pulse, wfi_pulse}), 64'({e_op[13], e_op[14], e_op[20]}));
        checks++;
        if (arg_out !== e_arg) fail("R10", "arg_out", 64'(arg_out), 64'(e_arg));
        checks++;
        if ($countones({op_vec, rd_sel, undef}) != 1)
            fail("R11", "outcome count", 64'($countones({op_vec, rd_sel, undef})), 64'd1);
    endtask

    // Check that nothing is raised in a cycle with no access.
    task automatic check_idle();
        @(negedge clk);
        checks++;
        if ({op_vec, rd_sel, undef, arg_out, rd_data, dsb_pulse, dmb_pulse, wfi_pulse} !== '0)
            fail("R11", "idle outputs", 64'({op_vec, rd_sel, undef}), 64'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if ({op_vec, rd_sel, undef, arg_out, rd_data} !== '0)
            fail("R11", "reset state", 64'({op_vec, rd_sel, undef}), 64'd0);
        rst_n = 1'b1;
        check_idle();
        for (int w = 0; w < 2; w++)
            for (int p = 0; p < 2; p++)
                for (int o = 0; o < 2; o++)
                    for (int crm = 0; crm < 16; crm++)
                        for (int op2 = 0; op2 < 8; op2++) begin
                            run_one(w[0], p[0], (o != 0) ? (crm % 7) + 1 : 0, crm, op2,
                                    32'hDEAD_BEEF ^ (32'(crm) << 8) ^ (32'(op2) * 32'h0101_0013),
                                    op2[0], crm[0] ^ w[0]);
                            if (op2 == 7) check_idle();
                        end
        // Argument masking with all ones (R10) and both status values (R3, R4).
        run_one(1, 1, 0, 10, 1, 32'hFFFF_FFFF, 0, 0);
        run_one(1, 1, 0, 5, 7, 32'hFFFF_FFFF, 0, 0);
        run_one(1, 1, 0, 14, 2, 32'hFFFF_FFFF, 0, 0);
        run_one(0, 1, 0, 10, 6, 32'h0, 1, 0);
        run_one(0, 1, 0, 10, 6, 32'h0, 0, 1);
        run_one(0, 0, 0, 12, 4, 32'h0, 0, 1);
        run_one(0, 0, 0, 12, 4, 32'h0, 1, 0);
        check_idle();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule